// File: doc/BRIEF.md
# Configuration Port Write Queue Controller

This block sits between a processor's register bus and a 32-bit device configuration port. Software writes command words one at a time into a data register, which pushes them into an internal queue. It then sets a start bit in the control register. From the next clock edge the block sends the queued words to the port, one per clock, with a qualifying enable. It pauses whenever the port signals busy.

Software learns how many more words fit from a free-slot register. It learns that the transfer has finished from the start bit, which stays set until the queue runs dry and then clears by itself, or from a done flag. A start is honoured only after the device reports that its start-up sequence is complete. An interrupt can flag the end of a transfer and an externally signalled readback event. It is gated by per-source enables and by a global enable.

The register bus has single-cycle writes and a combinational read path. Word addresses: 0 queue data (write only, reads 0), 1 free slots, 2 control, 3 status, 4 pending interrupts, 5 interrupt enables, 6 global interrupt enable.

Top module: `cfgport_wfifo_ctrl`

## Requirements
- R1: After reset, free slots read DEPTH (16), control, status bit 0, pending, interrupt enables and global enable read 0, and `port_en` and `irq` are low.
- R2: Each write to address 0 enqueues `reg_wdata`. During a transfer, words leave in write order, one per clock. Each word appears on `port_data` with `port_en` high in the cycle after the edge at which it was taken.
- R3: Address 1 reads DEPTH minus the number of queued words. A write to address 0 while the queue is full is discarded.
- R4: Writing 1 to control bit 0 starts a transfer only while `startup_done` is high; otherwise the write has no effect. Bit 0 reads 1 from the edge after the start write until the edge at which the queue is found empty, and then reads 0.
- R5: While `port_busy` is high at a clock edge, no word is taken, and `port_en` is low in the following cycle.
- R6: Status bit 0 (done) is set when a transfer ends and is cleared by writing 1 to it. Status bit 1 mirrors `startup_done`.
- R7: Address 5 holds only bit 0 (queue-empty source) and bit 1 (readback-pending source). Reading it returns exactly the bits last written there, and all other bits read 0.
- R8: Address 6 bit 0 is the global interrupt enable. It is written and read back without affecting the per-source enables.
- R9: Pending bit 0 is set when a transfer ends. Pending bit 1 is set by a high `rd_pend_evt`. Writing 1 to a pending bit clears it. A set event in the same cycle as the clear wins.
- R10: `irq` equals global enable AND the OR over bits of (enables AND pending).
- R11: A queue write accepted in the same cycle that a word is taken leaves the free-slot count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| startup_done | input | 1 | Device start-up complete |
| rd_pend_evt | input | 1 | Readback data pending event |
| port_busy | input | 1 | Configuration port busy |
| port_data | output | 32 | Word to configuration port |
| port_en | output | 1 | Word on port_data is valid |
| irq | output | 1 | Interrupt request |

## Verification
The coincidence of interest is a software push into the queue landing on the same edge as the drain logic taking a word. The bench loads four words while the port is busy and starts the transfer. It then releases `port_busy` in the same cycle as a fresh data write, so that a pop and a push share one edge. It judges the result by the free-slot count staying at twelve. The scoreboard also confirms that the late word leaves last, in order. A second coincidence, the end-of-transfer set against a clear of the same pending bit, is governed by the set-wins rule.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int SRC_N  = 2;
  localparam int SRC_WEMPTY = 0;
  localparam int SRC_RDP    = 1;

  typedef enum logic [ADDR_W-1:0] {
    RA_QDATA = 3'd0,
    RA_FREE  = 3'd1,
    RA_CTRL  = 3'd2,
    RA_STAT  = 3'd3,
    RA_PEND  = 3'd4,
    RA_IEN   = 3'd5,
    RA_GIEN  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/cfgw_fifo.sv
module cfgw_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] free_slots
);
  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] slots_left(input logic [CW-1:0] used);
    return CW'(DEPTH) - used;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign empty      = (count == '0);
  assign full       = (count == CW'(DEPTH));
  assign push_ok    = push && !full;
  assign pop_ok     = pop && !empty;
  assign head       = mem[rptr];
  assign free_slots = slots_left(count);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= ptr_next(wptr);
      if (pop_ok)  rptr <= ptr_next(rptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == CW'(DEPTH)));
  // R11
  push_pop_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && pop && !empty) |=> $stable(count));
endmodule

// File: rtl/cfgw_drain.sv
module cfgw_drain #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          startup_ok,
  input  logic          busy,
  input  logic          q_empty,
  input  logic [DW-1:0] q_head,
  input  logic          done_clr,
  output logic          pop,
  output logic          active,
  output logic          xfer_end,
  output logic          done,
  output logic [DW-1:0] port_data,
  output logic          port_en
);
  assign pop      = active && !q_empty && !busy;
  assign xfer_end = active && q_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      done      <= 1'b0;
      port_en   <= 1'b0;
      port_data <= '0;
    end else begin
      if (!active && start_req && startup_ok) active <= 1'b1;
      else if (xfer_end)                      active <= 1'b0;
      if (xfer_end)      done <= 1'b1;
      else if (done_clr) done <= 1'b0;
      port_en <= pop;
      if (pop) port_data <= q_head;
    end
  end

  // R4
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(startup_ok));
  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !port_en);
  // R6
  end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && q_empty) |=> (!active && done));
endmodule

// File: rtl/cfgw_irq.sv
module cfgw_irq
  import cfgw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] set_evt,
  input  logic             pend_wr,
  input  logic             ien_wr,
  input  logic             gien_wr,
  input  logic [SRC_N-1:0] wbits,
  output logic [SRC_N-1:0] pend,
  output logic [SRC_N-1:0] ien,
  output logic             gien,
  output logic             irq
);
  logic [SRC_N-1:0] clr_mask;
  assign clr_mask = pend_wr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      ien  <= '0;
      gien <= 1'b0;
    end else begin
      pend <= (pend & ~clr_mask) | set_evt;
      if (ien_wr)  ien  <= wbits;
      if (gien_wr) gien <= wbits[0];
    end
  end

  assign irq = gien && |(ien & pend);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt[SRC_WEMPTY] |=> pend[SRC_WEMPTY]);
  // R7
  ien_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ien_wr |=> (ien == $past(wbits)));
endmodule

// File: rtl/cfgport_wfifo_ctrl.sv
module cfgport_wfifo_ctrl
  import cfgw_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              startup_done,
  input  logic              rd_pend_evt,
  input  logic              port_busy,
  output logic [DATA_W-1:0] port_data,
  output logic              port_en,
  output logic              irq
);
  logic              wr_q, wr_ctrl, wr_stat, wr_pend, wr_ien, wr_gien;
  logic              q_pop, q_empty, q_full;
  logic [DATA_W-1:0] q_head;
  logic [CW-1:0]     q_free;
  logic              active, xfer_end, done;
  logic [SRC_N-1:0]  pend, ien, set_evt;
  logic              gien;

  assign wr_q    = reg_wr && (reg_addr == RA_QDATA);
  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign wr_pend = reg_wr && (reg_addr == RA_PEND);
  assign wr_ien  = reg_wr && (reg_addr == RA_IEN);
  assign wr_gien = reg_wr && (reg_addr == RA_GIEN);

  cfgw_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(wr_q), .push_data(reg_wdata), .pop(q_pop),
    .head(q_head), .empty(q_empty), .full(q_full), .free_slots(q_free)
  );

  cfgw_drain #(.DW(DATA_W)) u_drain (
    .clk(clk), .rst_n(rst_n),
    .start_req(wr_ctrl && reg_wdata[0]), .startup_ok(startup_done),
    .busy(port_busy), .q_empty(q_empty), .q_head(q_head),
    .done_clr(wr_stat && reg_wdata[0]),
    .pop(q_pop), .active(active), .xfer_end(xfer_end), .done(done),
    .port_data(port_data), .port_en(port_en)
  );

  always_comb begin
    set_evt = '0;
    set_evt[SRC_WEMPTY] = xfer_end;
    set_evt[SRC_RDP]    = rd_pend_evt;
  end

  cfgw_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt),
    .pend_wr(wr_pend), .ien_wr(wr_ien), .gien_wr(wr_gien),
    .wbits(reg_wdata[SRC_N-1:0]),
    .pend(pend), .ien(ien), .gien(gien), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_FREE: reg_rdata = DATA_W'(q_free);
      RA_CTRL: reg_rdata[0] = active;
      RA_STAT: reg_rdata[1:0] = {startup_done, done};
      RA_PEND: reg_rdata[SRC_N-1:0] = pend;
      RA_IEN:  reg_rdata[SRC_N-1:0] = ien;
      RA_GIEN: reg_rdata[0] = gien;
      default: reg_rdata = '0;
    endcase
  end

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq == (gien && |(ien & pend))) && !(q_full && q_free != '0));
endmodule

// File: tb/cfgport_wfifo_ctrl_tb.sv
`timescale 1ns/1ps
module cfgport_wfifo_ctrl_tb;
  localparam int DEPTH = 16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        startup_done = 1'b0;
  logic        rd_pend_evt = 1'b0;
  logic        port_busy = 1'b0;
  logic [31:0] port_data;
  logic        port_en;
  logic        irq;

  int total = 0;
  int bad = 0;
  int seen = 0;
  int mcount = 0;
  logic [31:0] sbq[$];

  always #10 clk = ~clk;

  cfgport_wfifo_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .startup_done(startup_done), .rd_pend_evt(rd_pend_evt),
    .port_busy(port_busy), .port_data(port_data), .port_en(port_en), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // driver: push into queue and scoreboard when it will be accepted
  task automatic push_word(input logic [31:0] w);
    if (mcount < DEPTH) begin
      sbq.push_back(w);
      mcount++;
    end
    wr(3'd0, w);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && port_en) begin
      seen++;
      mcount--;
      if (sbq.size() == 0) chk("R2 unexpected word", port_data, 32'hxxxxxxxx);
      else chk("R2 order", port_data, sbq.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset
    rd(3'd1, v); chk("R1 free", v, DEPTH);
    rd(3'd2, v); chk("R1 ctrl", v, 0);
    rd(3'd3, v); chk("R1 status", v, 0);
    rd(3'd4, v); chk("R1 pend", v, 0);
    rd(3'd5, v); chk("R1 ien", v, 0);
    rd(3'd6, v); chk("R1 gien", v, 0);
    chk("R1 port_en/irq", {port_en, irq}, 0);

    // R4: start ignored before startup
    push_word(32'hA0000001); push_word(32'hA0000002); push_word(32'hA0000003);
    wr(3'd2, 1);
    idle(4);
    rd(3'd2, v); chk("R4 start ignored", v, 0);
    chk("R4 no words", seen, 0);
    rd(3'd1, v); chk("R3 free 13", v, 13);
    rd(3'd3, v); chk("R6 eos mirror low", v, 0);

    // R2/R4 drain after startup
    startup_done = 1'b1;
    wr(3'd2, 1);
    rd(3'd2, v); chk("R4 bit held", v, 1);
    idle(6);
    chk("R2 three words", seen, 3);
    rd(3'd2, v); chk("R4 self clear", v, 0);
    rd(3'd3, v); chk("R6 done+eos", v, 3);
    rd(3'd4, v); chk("R9 wempty pend", v, 1);
    chk("R10 irq masked", irq, 0);
    wr(3'd3, 1);
    rd(3'd3, v); chk("R6 done cleared", v, 2);

    // R7 / R8
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R7 ien only two bits", v, 3);
    wr(3'd5, 32'h2);
    rd(3'd5, v); chk("R7 ien readback", v, 2);
    wr(3'd6, 1);
    rd(3'd6, v); chk("R8 gien", v, 1);
    rd(3'd5, v); chk("R8 ien untouched", v, 2);
    chk("R10 irq off (src disabled)", irq, 0);
    wr(3'd5, 32'h1);
    chk("R10 irq on", irq, 1);
    wr(3'd6, 0);
    chk("R10 gien gates", irq, 0);
    wr(3'd6, 1);
    wr(3'd4, 1);
    rd(3'd4, v); chk("R9 w1c", v, 0);
    chk("R10 irq cleared", irq, 0);

    // R9 readback pending
    @(negedge clk); rd_pend_evt = 1'b1;
    @(negedge clk); rd_pend_evt = 1'b0;
    rd(3'd4, v); chk("R9 rdp pend", v, 2);
    chk("R10 rdp masked", irq, 0);
    wr(3'd5, 32'h3);
    chk("R10 rdp irq", irq, 1);
    wr(3'd4, 2);
    chk("R9 rdp clear", irq, 0);

    // R3 full drop
    for (int i = 0; i < DEPTH + 1; i++) push_word(32'hB000_0000 + i);
    rd(3'd1, v); chk("R3 free full", v, 0);
    seen = 0;
    wr(3'd2, 1);
    idle(DEPTH + 4);
    chk("R3 extra dropped", seen, DEPTH);
    chk("R3 queue empty", sbq.size(), 0);

    // R5 busy pause + R11 coincidence
    wr(3'd4, 3);
    seen = 0;
    port_busy = 1'b1;
    for (int i = 0; i < 4; i++) push_word(32'hC000_0000 + i);
    wr(3'd2, 1);
    idle(5);
    chk("R5 paused", seen, 0);
    rd(3'd2, v); chk("R5 still active", v, 1);
    rd(3'd1, v); chk("R11 free before", v, 12);
    @(negedge clk);
    port_busy = 1'b0;
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'hC0FFEE00;
    sbq.push_back(32'hC0FFEE00); mcount++;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(3'd1, v); chk("R11 free same", v, 12);
    idle(8);
    chk("R5 resumed all", seen, 5);
    chk("R2 scoreboard drained", sbq.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule